// File: doc/BRIEF.md
# Column Inverse-DCT Pixel Reconstruction Stage

This block performs the second, vertical half of an 8x8 separable integer inverse DCT. It takes one column of eight signed 16-bit intermediate values, already produced by a horizontal pass and transposed. It applies the 8-point butterfly with fixed 14-bit-scaled cosine weights, adds a rounding bias and scales the result down by 20 bits. Every column is transformed in full. No path skips work for columns that hold only a DC term or only low-order terms.

The descaled results leave through one of three output modes, chosen with each column. Raw mode passes the signed 16-bit values through. Put mode saturates each value to an unsigned 8-bit pixel. Add mode adds each value to a prediction pixel from the same output line and saturates the sum to 8 bits. With each sample the block also gives its line offset, the sample index times a programmable line stride, so that a downstream writer can place the eight samples on consecutive picture lines.

The block accepts one column per clock cycle, with no stalls. All eight results of a column appear together two cycles later.

Top module: `idct_col_recon`

## Requirements
- R1: While reset is asserted and after it is released, until the first column comes out, `out_valid` is 0 and every lane of `out_data` and `out_off` is 0.
- R2: A column sampled on a rising edge where `in_valid` is 1 appears with `out_valid` = 1 exactly two rising edges later, and not before. Columns may arrive on consecutive cycles and come out on consecutive cycles, in the same order.
- R3: Coefficient lane j of `in_coef` (bits 16j+15..16j) is c[j], as signed two's complement. With weights W1=22725, W2=21407, W3=19266, W4=16383, W5=12873, W6=8867, W7=4520 and bias 2^19, the even terms are formed as follows. E0=W4(c0+c4)+W2c2+W6c6. E1=W4(c0-c4)+W6c2-W2c6. E2=W4(c0-c4)-W6c2+W2c6. E3=W4(c0+c4)-W2c2-W6c6.
- R4: The odd terms are O0=W1c1+W3c3+W5c5+W7c7, O1=W3c1-W7c3-W1c5-W5c7, O2=W5c1-W1c3+W7c5+W3c7 and O3=W7c1-W5c3+W3c5-W1c7. For k=0..3, sample k is (Ek+Ok+2^19)>>20 and sample 7-k is (Ek-Ok+2^19)>>20. Both shifts are arithmetic, computed without overflow.
- R5: Mode 0 (raw): output lane k (bits 16k+15..16k of `out_data`) is the low 16 bits of sample k in two's complement, with no clamping.
- R6: Mode 1 (put): output lane k is sample k clamped to 0..255 and zero-extended to 16 bits.
- R7: Mode 2 (add): output lane k is (pred lane k + sample k) clamped to 0..255, where pred lane k is bits 8k+7..8k of `in_pred`. The prediction is added after the 20-bit shift.
- R8: Mode 3 gives the same results as raw mode.
- R9: Offset lane k (bits 15k+14..15k of `out_off`) is k times the `in_stride` value sampled with the column.
- R10: In raw and put modes the prediction input has no effect on the results.
- R11: While no new column is in flight, `out_data` and `out_off` hold their last values, and inputs presented with `in_valid` = 0 change neither.
- R12: A column with only c0 non-zero is transformed like any other, so all eight samples equal (W4·c0+2^19)>>20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Column present on the inputs this cycle |
| in_mode | input | 2 | Output mode: 0 raw, 1 put, 2 add, 3 same as raw |
| in_coef | input | 128 | Eight signed 16-bit column values, lane j at bits 16j+15..16j |
| in_pred | input | 64 | Eight 8-bit prediction pixels, lane k at bits 8k+7..8k |
| in_stride | input | 12 | Line stride used to form the offsets |
| out_valid | output | 1 | Results of one column are on the outputs |
| out_data | output | 128 | Eight 16-bit results, lane k at bits 16k+15..16k |
| out_off | output | 120 | Eight 15-bit line offsets, lane k at bits 15k+14..15k |

## Verification
Every result of a column is due two rising edges after the edge that sampled `in_valid`. The products and butterfly inputs are registered on the first edge, and the clamped or added pixels and the offsets on the second. The bench changes inputs only at falling edges. One falling edge after driving a column it checks that `out_valid` is still low. At the next falling edge it compares all eight lanes and offsets with values it computes from the weight equations. In the back-to-back test, each column is checked at its own falling edge, one cycle after the previous column. In the hold test, the outputs are compared with the last column's values at every falling edge while new input data is shown with `in_valid` low.

// File: rtl/idct_col_pkg.sv
package idct_col_pkg;

  // cosine weights, cos(i*pi/16)*sqrt(2) scaled by 2^14
  localparam int WT1 = 22725;
  localparam int WT2 = 21407;
  localparam int WT3 = 19266;
  localparam int WT4 = 16383;
  localparam int WT5 = 12873;
  localparam int WT6 = 8867;
  localparam int WT7 = 4520;

  typedef enum logic [1:0] {
    MODE_RAW = 2'd0,
    MODE_PUT = 2'd1,
    MODE_ADD = 2'd2,
    MODE_RSV = 2'd3
  } recon_mode_e;

endpackage

// File: rtl/idct_col_rstsync.sv
module idct_col_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/idct_col_even.sv
// Even half of the 8-point butterfly: terms from c0, c2, c4, c6 plus rounding bias.
module idct_col_even #(
  parameter int COEF_W = 16,
  parameter int ACC_W  = 36,
  parameter int SHIFT  = 20
) (
  input  logic [4*COEF_W-1:0] ev_i,   // lane 0..3 = c0, c2, c4, c6
  output logic [4*ACC_W-1:0]  a_o     // lane 0..3 = E0..E3 + bias
);
  import idct_col_pkg::*;

  localparam logic signed [ACC_W-1:0] K2 = ACC_W'(WT2);
  localparam logic signed [ACC_W-1:0] K4 = ACC_W'(WT4);
  localparam logic signed [ACC_W-1:0] K6 = ACC_W'(WT6);
  localparam logic signed [ACC_W-1:0] BIAS =
    {{(ACC_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};

  logic signed [ACC_W-1:0] x [4];

  for (genvar i = 0; i < 4; i++) begin : g_ext
    assign x[i] = {{(ACC_W-COEF_W){ev_i[i*COEF_W+COEF_W-1]}}, ev_i[i*COEF_W +: COEF_W]};
  end

  logic signed [ACC_W-1:0] p0, p4, p2w2, p2w6, p6w6, p6w2;
  logic signed [ACC_W-1:0] e0, e1, e2, e3;

  always_comb begin
    p0   = K4 * x[0];
    p4   = K4 * x[2];
    p2w2 = K2 * x[1];
    p2w6 = K6 * x[1];
    p6w6 = K6 * x[3];
    p6w2 = K2 * x[3];
    e0 = p0 + p4 + p2w2 + p6w6 + BIAS;
    e1 = p0 - p4 + p2w6 - p6w2 + BIAS;
    e2 = p0 - p4 - p2w6 + p6w2 + BIAS;
    e3 = p0 + p4 - p2w2 - p6w6 + BIAS;
  end

  assign a_o = {e3, e2, e1, e0};

endmodule

// File: rtl/idct_col_odd.sv
// Odd half of the 8-point butterfly: terms from c1, c3, c5, c7.
module idct_col_odd #(
  parameter int COEF_W = 16,
  parameter int ACC_W  = 36
) (
  input  logic [4*COEF_W-1:0] od_i,   // lane 0..3 = c1, c3, c5, c7
  output logic [4*ACC_W-1:0]  b_o     // lane 0..3 = O0..O3
);
  import idct_col_pkg::*;

  localparam logic signed [ACC_W-1:0] K1 = ACC_W'(WT1);
  localparam logic signed [ACC_W-1:0] K3 = ACC_W'(WT3);
  localparam logic signed [ACC_W-1:0] K5 = ACC_W'(WT5);
  localparam logic signed [ACC_W-1:0] K7 = ACC_W'(WT7);

  logic signed [ACC_W-1:0] x [4];

  for (genvar i = 0; i < 4; i++) begin : g_ext
    assign x[i] = {{(ACC_W-COEF_W){od_i[i*COEF_W+COEF_W-1]}}, od_i[i*COEF_W +: COEF_W]};
  end

  logic signed [ACC_W-1:0] o0, o1, o2, o3;

  always_comb begin
    o0 = K1 * x[0] + K3 * x[1] + K5 * x[2] + K7 * x[3];
    o1 = K3 * x[0] - K7 * x[1] - K1 * x[2] - K5 * x[3];
    o2 = K5 * x[0] - K1 * x[1] + K7 * x[2] + K3 * x[3];
    o3 = K7 * x[0] - K5 * x[1] + K3 * x[2] - K1 * x[3];
  end

  assign b_o = {o3, o2, o1, o0};

endmodule

// File: rtl/idct_col_lane.sv
// One output lane: descale, then raw pass-through, clamp, or add-and-clamp.
module idct_col_lane #(
  parameter int SUM_W = 37,
  parameter int SHIFT = 20,
  parameter int PIX_W = 8,
  parameter int OUT_W = 16
) (
  input  logic signed [SUM_W-1:0]   sum_i,
  input  idct_col_pkg::recon_mode_e mode_i,
  input  logic [PIX_W-1:0]          pred_i,
  output logic [OUT_W-1:0]          pix_o
);
  import idct_col_pkg::*;

  localparam logic signed [SUM_W:0] PMAX = {{(SUM_W+1-PIX_W){1'b0}}, {PIX_W{1'b1}}};

  logic signed [SUM_W-1:0] scaled;
  logic signed [SUM_W:0]   scaled_x;
  logic signed [SUM_W:0]   with_pred;

  assign scaled    = sum_i >>> SHIFT;
  assign scaled_x  = {scaled[SUM_W-1], scaled};
  assign with_pred = scaled_x + {{(SUM_W+1-PIX_W){1'b0}}, pred_i};

  function automatic logic [PIX_W-1:0] sat_pix(input logic signed [SUM_W:0] v);
    if (v < 0)         return '0;
    else if (v > PMAX) return {PIX_W{1'b1}};
    else               return v[PIX_W-1:0];
  endfunction

  always_comb begin
    unique case (mode_i)
      MODE_PUT: pix_o = {{(OUT_W-PIX_W){1'b0}}, sat_pix(scaled_x)};   // R6
      MODE_ADD: pix_o = {{(OUT_W-PIX_W){1'b0}}, sat_pix(with_pred)};  // R7
      default:  pix_o = scaled[OUT_W-1:0];                            // R5, R8
    endcase
  end

endmodule

// File: rtl/idct_col_recon.sv
module idct_col_recon #(
  parameter  int COEF_W   = 16,
  parameter  int WGT_W    = 16,
  parameter  int PIX_W    = 8,
  parameter  int OUT_W    = 16,
  parameter  int STRIDE_W = 12,
  parameter  int SHIFT    = 20,
  localparam int LANES    = 8,
  localparam int OFF_W    = STRIDE_W + $clog2(LANES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [1:0]                in_mode,
  input  logic [LANES*COEF_W-1:0]   in_coef,
  input  logic [LANES*PIX_W-1:0]    in_pred,
  input  logic [STRIDE_W-1:0]       in_stride,
  output logic                      out_valid,
  output logic [LANES*OUT_W-1:0]    out_data,
  output logic [LANES*OFF_W-1:0]    out_off
);
  import idct_col_pkg::*;

  localparam int HALF  = LANES / 2;
  localparam int ACC_W = COEF_W + WGT_W + 4;
  localparam int SUM_W = ACC_W + 1;

  // ---------------- reset release ----------------
  logic rst_q;

  idct_col_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  // ---------------- stage 1: products ----------------
  logic [HALF*COEF_W-1:0] ev_w, od_w;
  logic [HALF*ACC_W-1:0]  a_w, b_w;

  for (genvar i = 0; i < HALF; i++) begin : g_split
    assign ev_w[i*COEF_W +: COEF_W] = in_coef[(2*i)*COEF_W   +: COEF_W];
    assign od_w[i*COEF_W +: COEF_W] = in_coef[(2*i+1)*COEF_W +: COEF_W];
  end

  idct_col_even #(.COEF_W(COEF_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_even (
    .ev_i (ev_w),
    .a_o  (a_w)
  );

  idct_col_odd #(.COEF_W(COEF_W), .ACC_W(ACC_W)) u_odd (
    .od_i (od_w),
    .b_o  (b_w)
  );

  logic                   s1_en;
  logic                   s1_valid_d, s1_valid_q;
  logic [HALF*ACC_W-1:0]  s1_a_d, s1_a_q, s1_b_d, s1_b_q;
  recon_mode_e            s1_mode_d, s1_mode_q;
  logic [LANES*PIX_W-1:0] s1_pred_d, s1_pred_q;
  logic [STRIDE_W-1:0]    s1_stride_d, s1_stride_q;

  always_comb begin
    s1_en       = in_valid;
    s1_valid_d  = in_valid;
    s1_a_d      = a_w;
    s1_b_d      = b_w;
    s1_mode_d   = recon_mode_e'(in_mode);
    s1_pred_d   = in_pred;
    s1_stride_d = in_stride;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_valid_q  <= 1'b0;
      s1_a_q      <= '0;
      s1_b_q      <= '0;
      s1_mode_q   <= MODE_RAW;
      s1_pred_q   <= '0;
      s1_stride_q <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      if (s1_en) begin
        s1_a_q      <= s1_a_d;
        s1_b_q      <= s1_b_d;
        s1_mode_q   <= s1_mode_d;
        s1_pred_q   <= s1_pred_d;
        s1_stride_q <= s1_stride_d;
      end
    end
  end

  // ---------------- stage 2: butterfly, descale, reconstruct ----------------
  logic signed [SUM_W-1:0] sum_w [LANES];
  logic [LANES*OUT_W-1:0]  pix_w;
  logic [LANES*OFF_W-1:0]  off_w;

  for (genvar k = 0; k < HALF; k++) begin : g_bfly
    logic signed [SUM_W-1:0] a_x, b_x;
    assign a_x = {s1_a_q[k*ACC_W+ACC_W-1], s1_a_q[k*ACC_W +: ACC_W]};
    assign b_x = {s1_b_q[k*ACC_W+ACC_W-1], s1_b_q[k*ACC_W +: ACC_W]};
    assign sum_w[k]         = a_x + b_x;   // R4 sample k
    assign sum_w[LANES-1-k] = a_x - b_x;   // R4 sample 7-k
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    idct_col_lane #(
      .SUM_W (SUM_W),
      .SHIFT (SHIFT),
      .PIX_W (PIX_W),
      .OUT_W (OUT_W)
    ) u_lane (
      .sum_i  (sum_w[k]),
      .mode_i (s1_mode_q),
      .pred_i (s1_pred_q[k*PIX_W +: PIX_W]),
      .pix_o  (pix_w[k*OUT_W +: OUT_W])
    );
    assign off_w[k*OFF_W +: OFF_W] = OFF_W'(k) * {{(OFF_W-STRIDE_W){1'b0}}, s1_stride_q};  // R9
  end

  logic                   out_en;
  logic                   out_valid_d, out_valid_q;
  logic [LANES*OUT_W-1:0] out_data_d, out_data_q;
  logic [LANES*OFF_W-1:0] out_off_d, out_off_q;
  recon_mode_e            out_mode_d, out_mode_q;

  always_comb begin
    out_en      = s1_valid_q;
    out_valid_d = s1_valid_q;
    out_data_d  = pix_w;
    out_off_d   = off_w;
    out_mode_d  = s1_mode_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_off_q   <= '0;
      out_mode_q  <= MODE_RAW;
    end else begin
      out_valid_q <= out_valid_d;
      if (out_en) begin
        out_data_q <= out_data_d;
        out_off_q  <= out_off_d;
        out_mode_q <= out_mode_d;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_off   = out_off_q;

  // ---------------- assertions ----------------
  AST_STAGE1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> s1_valid_q);  // R2

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q)
    s1_valid_q |=> out_valid);  // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_q)
    !s1_valid_q |=> !out_valid);  // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    !s1_valid_q |=> ($stable(out_data) && $stable(out_off)));  // R11

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    AST_PIX_RANGE: assert property (@(posedge clk) disable iff (!rst_q)
      (out_valid && (out_mode_q == MODE_PUT || out_mode_q == MODE_ADD))
        |-> (out_data[k*OUT_W+PIX_W +: OUT_W-PIX_W] == '0));  // R6
    if (k > 0) begin : g_step
      AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_q)
        out_valid |-> (out_off[k*OFF_W +: OFF_W] ==
                       out_off[(k-1)*OFF_W +: OFF_W] + out_off[OFF_W +: OFF_W]));  // R9
    end
  end

endmodule

// File: tb/idct_col_recon_tb.sv
`timescale 1ns/1ps
module idct_col_recon_tb;

  localparam int CW  = 16;
  localparam int PW  = 8;
  localparam int OW  = 16;
  localparam int SW  = 12;
  localparam int OFW = 15;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [1:0]       in_mode;
  logic [8*CW-1:0]  in_coef;
  logic [8*PW-1:0]  in_pred;
  logic [SW-1:0]    in_stride;
  logic             out_valid;
  logic [8*OW-1:0]  out_data;
  logic [8*OFW-1:0] out_off;

  int errors = 0;
  int checks = 0;
  int unsigned seed = 32'h1234_5678;
  logic signed [15:0] tc [8];
  logic [7:0]         tp [8];
  int                 exp_tab [4][8];
  int                 exp_str [4];

  always #2 clk = ~clk;

  idct_col_recon u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_coef   (in_coef),
    .in_pred   (in_pred),
    .in_stride (in_stride),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_off   (out_off)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // reference sample k before the shift, from the weight equations
  function automatic longint ref_sum(int k);
    longint c [8];
    longint e [4];
    longint o [4];
    int j;
    for (int i = 0; i < 8; i++) c[i] = longint'(tc[i]);
    e[0] = 16383*(c[0]+c[4]) + 21407*c[2] + 8867*c[6];
    e[1] = 16383*(c[0]-c[4]) + 8867*c[2] - 21407*c[6];
    e[2] = 16383*(c[0]-c[4]) - 8867*c[2] + 21407*c[6];
    e[3] = 16383*(c[0]+c[4]) - 21407*c[2] - 8867*c[6];
    o[0] = 22725*c[1] + 19266*c[3] + 12873*c[5] + 4520*c[7];
    o[1] = 19266*c[1] - 4520*c[3] - 22725*c[5] - 12873*c[7];
    o[2] = 12873*c[1] - 22725*c[3] + 4520*c[5] + 19266*c[7];
    o[3] = 4520*c[1] - 12873*c[3] + 19266*c[5] - 22725*c[7];
    j = (k < 4) ? k : 7 - k;
    return (k < 4) ? (e[j] + o[j] + 524288) : (e[j] - o[j] + 524288);
  endfunction

  function automatic int clamp8(longint v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return int'(v);
  endfunction

  function automatic int exp_lane(int k, int mode);
    longint s;
    s = ref_sum(k) >>> 20;
    case (mode)
      1:       return clamp8(s);
      2:       return clamp8(s + longint'(tp[k]));
      default: return int'(s & 64'hFFFF);
    endcase
  endfunction

  task automatic calc_exp(input int slot, input int mode, input int stride);
    for (int k = 0; k < 8; k++) exp_tab[slot][k] = exp_lane(k, mode);
    exp_str[slot] = stride;
  endtask

  task automatic drive(input int mode, input int stride);
    for (int k = 0; k < 8; k++) begin
      in_coef[k*CW +: CW] = tc[k];
      in_pred[k*PW +: PW] = tp[k];
    end
    in_mode   = 2'(mode);
    in_stride = SW'(stride);
    in_valid  = 1'b1;
  endtask

  task automatic check_slot(input string req, input int slot);
    chk("R2", {req, " out_valid"}, longint'(out_valid), 1);
    for (int k = 0; k < 8; k++) begin
      chk(req, $sformatf("lane %0d data", k), longint'(out_data[k*OW +: OW]), longint'(exp_tab[slot][k]));
      chk("R9", $sformatf("lane %0d offset", k), longint'(out_off[k*OFW +: OFW]), longint'(k * exp_str[slot]));
    end
  endtask

  // one column: sampled on the first rising edge, due after the second
  task automatic send_one(input string req, input int mode, input int stride);
    calc_exp(0, mode, stride);
    @(negedge clk);
    drive(mode, stride);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", {req, " valid one cycle early"}, longint'(out_valid), 0);
    @(negedge clk);
    check_slot(req, 0);
  endtask

  task automatic fill_rand(input int shift_amt);
    for (int k = 0; k < 8; k++) begin
      tc[k] = 16'($signed(rnd() >> 16)) >>> shift_amt;
      tp[k] = 8'(rnd() >> 20);
    end
  endtask

  task automatic fill_dc(input int v);
    for (int k = 0; k < 8; k++) begin
      tc[k] = '0;
      tp[k] = 8'(rnd() >> 12);
    end
    tc[0] = 16'(v);
  endtask

  task automatic t_reset();
    chk("R1", "out_valid after reset", longint'(out_valid), 0);
    chk("R1", "out_data after reset", longint'(out_data == '0), 1);
    chk("R1", "out_off after reset", longint'(out_off == '0), 1);
  endtask

  task automatic t_dc_only();
    fill_dc(1000);
    send_one("R12", 0, 8);
    for (int k = 0; k < 8; k++)
      chk("R12", $sformatf("dc lane %0d", k), longint'(out_data[k*OW +: OW]), 16);
    fill_dc(-1000);
    send_one("R12", 0, 8);
    chk("R12", "negative dc lane 7", longint'(out_data[7*OW +: OW]), 16'hFFF0);
  endtask

  task automatic t_raw();
    for (int n = 0; n < 4; n++) begin
      fill_rand(n);
      send_one("R3 R4 R5", 0, 16 + n);
    end
    fill_rand(0);
    tc[1] = 16'sh7FFF; tc[3] = -16'sh7FFF; tc[5] = 16'sh7FFF; tc[7] = -16'sh7FFF;
    send_one("R4 R5", 0, 5);
  endtask

  task automatic t_put();
    fill_dc(32767);
    send_one("R6", 1, 1);
    chk("R6", "high clamp lane 0", longint'(out_data[0 +: OW]), 255);
    fill_dc(-32768);
    send_one("R6", 1, 1);
    chk("R6", "low clamp lane 3", longint'(out_data[3*OW +: OW]), 0);
    for (int n = 0; n < 3; n++) begin
      fill_rand(4 + n);
      send_one("R6 R10", 1, 33);
    end
  endtask

  task automatic t_pred_ignored();
    fill_rand(3);
    for (int k = 0; k < 8; k++) tp[k] = 8'h00;
    send_one("R10", 1, 2);
    for (int k = 0; k < 8; k++) tp[k] = 8'hFF;
    send_one("R10", 1, 2);
    send_one("R10", 0, 2);
  endtask

  task automatic t_add();
    for (int n = 0; n < 3; n++) begin
      fill_rand(5 + n);
      send_one("R7", 2, 64);
    end
    fill_dc(1000);
    for (int k = 0; k < 8; k++) tp[k] = 8'd250;
    send_one("R7", 2, 64);
    chk("R7", "add high clamp lane 5", longint'(out_data[5*OW +: OW]), 255);
    fill_dc(-1000);
    for (int k = 0; k < 8; k++) tp[k] = 8'd5;
    send_one("R7", 2, 64);
    chk("R7", "add low clamp lane 2", longint'(out_data[2*OW +: OW]), 0);
    fill_dc(-100);
    for (int k = 0; k < 8; k++) tp[k] = 8'd100;
    send_one("R7", 2, 64);
    chk("R7", "add no clamp lane 6", longint'(out_data[6*OW +: OW]), 100 + ((-1638300 + 524288) >>> 20));
  endtask

  task automatic t_mode3();
    fill_rand(1);
    send_one("R8", 3, 7);
  endtask

  task automatic t_stride();
    fill_rand(6);
    send_one("R9", 1, 0);
    send_one("R9", 1, 4095);
    send_one("R9", 2, 1);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    fill_rand(2); calc_exp(1, 0, 10); drive(0, 10);
    @(negedge clk);
    fill_rand(5); calc_exp(2, 1, 20); drive(1, 20);
    @(negedge clk);
    fill_rand(6); calc_exp(3, 2, 30); drive(2, 30);
    check_slot("R2 first", 1);
    @(negedge clk);
    in_valid = 1'b0;
    check_slot("R2 second", 2);
    @(negedge clk);
    check_slot("R2 third", 3);
    @(negedge clk);
    chk("R2", "valid drops after burst", longint'(out_valid), 0);
  endtask

  task automatic t_hold();
    logic [8*OW-1:0]  held_d;
    logic [8*OFW-1:0] held_o;
    fill_rand(3);
    send_one("R11", 0, 12);
    held_d = out_data;
    held_o = out_off;
    for (int n = 0; n < 4; n++) begin
      fill_rand(0);
      for (int k = 0; k < 8; k++) begin
        in_coef[k*CW +: CW] = tc[k];
        in_pred[k*PW +: PW] = tp[k];
      end
      in_mode   = 2'(n);
      in_stride = SW'(n * 100 + 1);
      in_valid  = 1'b0;
      @(negedge clk);
      chk("R11", "data held", longint'(out_data == held_d), 1);
      chk("R11", "offset held", longint'(out_off == held_o), 1);
      chk("R11", "valid low", longint'(out_valid), 0);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_mode   = 2'd0;
    in_coef   = '0;
    in_pred   = '0;
    in_stride = '0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dc_only();
    t_raw();
    t_put();
    t_pred_ignored();
    t_add();
    t_mode3();
    t_stride();
    t_back_to_back();
    t_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule